// File: doc/BRIEF.md
# Burst Address Sequencer

This block turns a single burst request into the ordered stream of byte addresses that a double-data-rate memory bus walks through. The request holds a start address, a burst kind, a wrap-size code and a beat count. Every beat carries one aligned byte pair, so each accepted beat moves the address on by two bytes.

A wrapped burst circles inside a group whose size is set by the code and which is aligned to its own size. A linear burst counts upward and ignores group edges. A hybrid burst makes exactly one full wrapped pass and then carries on linearly from the first byte of the next group.

The address stream leaves the block on a valid/ready interface. The address holds while the consumer stalls. `start_i` and the two flags are plain control and status pins. A new start may be given at any time, and it drops whatever burst is in flight.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset `addr_valid_o`, `done_o` and `wrap_done_o` are all low.
- R2: A start loads the start address with bit 0 cleared. `addr_valid_o` is high from the next cycle, and `addr_hi_o` is always `addr_lo_o` plus one.
- R3: While `addr_valid_o` is high and `addr_ready_i` is low, valid stays high and the address does not change. A beat is accepted only when valid and ready are both high at a clock edge.
- R4: Burst kinds 1 and 3 are linear. Each accepted beat adds 2 to the address, and group boundaries are crossed freely.
- R5: Burst kind 0 is wrapped, with a group of 16 << code bytes (code 0..3 gives 16, 32, 64 and 128 bytes, that is 8, 16, 32 and 64 beats). After the group's last pair the address returns to the group's first byte, and it never leaves the group.
- R6: A wrapped pass that starts in the middle of a group visits every byte pair of the group exactly once before repeating.
- R7: For burst kind 2 (hybrid), the beat after the first group-size/2 beats goes to the group base plus the group size. From there the address counts linearly.
- R8: `wrap_done_o` rises after the group-size/2-th accepted beat of a wrapped or hybrid burst. It stays high until the next start and is never set in a linear burst.
- R9: After the number of accepted beats given by `beat_count_i` (0 is taken as 1), `addr_valid_o` falls and `done_o` rises. `done_o` stays high until the next start.
- R10: A start while a burst is in flight drops that burst and begins the new one at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the request inputs |
| start_addr_i | input | ADDR_W | First byte address |
| burst_kind_i | input | 2 | 0 wrapped, 1 linear, 2 hybrid, 3 linear |
| wrap_code_i | input | 2 | Group size code, 16 << code bytes |
| beat_count_i | input | CNT_W | Beats in the burst |
| addr_valid_o | output | 1 | Address pair is valid |
| addr_ready_i | input | 1 | Consumer takes the pair |
| addr_lo_o | output | ADDR_W | Even byte address of the pair |
| addr_hi_o | output | ADDR_W | Odd byte address of the pair |
| wrap_done_o | output | 1 | A full wrapped pass has completed |
| done_o | output | 1 | The requested beats have all been accepted |

## Verification
The assertions assume that the request inputs matter only in the cycle `start_i` is high, and that `addr_ready_i` is a clean level sampled at the rising edge. The bench changes every input one time unit after the rising edge and reads outputs on the falling edge. It pulses start for one cycle at a time, with ready held low, and gives an overlapping start only in the restart case. The ready pattern stalls in a fixed rhythm, so the stall, wrap-edge and hybrid-switch cycles all fall on both accepted and refused beats.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    BK_WRAP    = 2'd0,
    BK_LINEAR  = 2'd1,
    BK_HYBRID  = 2'd2,
    BK_LINEAR2 = 2'd3
  } burst_kind_e;

  localparam int unsigned BYTES_PER_BEAT = 2;

  function automatic logic kind_is_linear(input burst_kind_e k);
    return (k == BK_LINEAR) || (k == BK_LINEAR2);
  endfunction
endpackage

// File: rtl/burst_seq_grp.sv
module burst_seq_grp #(
  parameter int ADDR_W   = 24,
  parameter int CODE_W   = 2,
  parameter int MIN_LOG2 = 4,
  parameter int PASS_W   = 6
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [ADDR_W-1:0] grp_mask_o,
  output logic [PASS_W-1:0] pass_last_o
);
  localparam int NUM_CODES = 1 << CODE_W;

  logic [ADDR_W-1:0] mask_tbl [NUM_CODES];
  logic [PASS_W-1:0] pass_tbl [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_size
    assign mask_tbl[g] = ADDR_W'((64'd1 << (MIN_LOG2 + g)) - 64'd1);
    assign pass_tbl[g] = PASS_W'((64'd1 << (MIN_LOG2 + g - 1)) - 64'd1);
  end

  assign grp_mask_o  = mask_tbl[code_i];
  assign pass_last_o = pass_tbl[code_i];
endmodule

// File: rtl/burst_seq_ctr.sv
module burst_seq_ctr #(
  parameter int CNT_W  = 12,
  parameter int PASS_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PASS_W-1:0] pass_last_i,
  output logic              last_beat_o,
  output logic              pass_end_o
);
  logic [CNT_W-1:0]  beat_q, cnt_q;
  logic [PASS_W-1:0] pass_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      cnt_q  <= '0;
      pass_q <= '0;
    end else if (load_i) begin
      beat_q <= '0;
      cnt_q  <= count_i;
      pass_q <= '0;
    end else if (step_i) begin
      beat_q <= beat_q + 1'b1;
      pass_q <= pass_end_o ? '0 : pass_q + 1'b1;
    end
  end

  assign last_beat_o = ({1'b0, beat_q} + 1'b1) >= {1'b0, cnt_q};
  assign pass_end_o  = (pass_q == pass_last_i);

  // R8: the position inside a pass never runs past the pass length
  a_r8_pass_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_q <= pass_last_i);
endmodule

// File: rtl/burst_seq_next.sv
module burst_seq_next #(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              wrap_active_i,
  input  logic              hybrid_i,
  input  logic              pass_end_i,
  output logic [ADDR_W-1:0] next_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(burst_seq_pkg::BYTES_PER_BEAT);

  logic [ADDR_W-1:0] base, bumped, wrapped;

  always_comb begin
    base    = cur_i & ~mask_i;
    bumped  = cur_i + STEP;
    wrapped = base | (bumped & mask_i);
    if (!wrap_active_i)               next_o = bumped;
    else if (hybrid_i && pass_end_i)  next_o = base + mask_i + 1'b1;
    else                              next_o = wrapped;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int CNT_W    = 12,
  parameter int CODE_W   = 2,
  parameter int MIN_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [1:0]        burst_kind_i,
  input  logic [CODE_W-1:0] wrap_code_i,
  input  logic [CNT_W-1:0]  beat_count_i,
  output logic              addr_valid_o,
  input  logic              addr_ready_i,
  output logic [ADDR_W-1:0] addr_lo_o,
  output logic [ADDR_W-1:0] addr_hi_o,
  output logic              wrap_done_o,
  output logic              done_o
);
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int PASS_W    = MIN_LOG2 + NUM_CODES - 2;

  logic [ADDR_W-1:0] addr_q, next_addr, grp_mask;
  logic [PASS_W-1:0] pass_last;
  logic [CODE_W-1:0] code_q;
  burst_kind_e       kind_q;
  logic busy_q, done_q, wd_q, hyb_lin_q;
  logic fire, last_beat, pass_end, is_lin, wrap_active;

  assign fire        = busy_q & addr_ready_i;
  assign is_lin      = kind_is_linear(kind_q);
  assign wrap_active = !is_lin && !hyb_lin_q;

  burst_seq_grp #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .MIN_LOG2(MIN_LOG2), .PASS_W(PASS_W)) grp_i (
    .code_i(code_q), .grp_mask_o(grp_mask), .pass_last_o(pass_last));

  burst_seq_ctr #(.CNT_W(CNT_W), .PASS_W(PASS_W)) ctr_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(start_i), .step_i(fire),
    .count_i(beat_count_i), .pass_last_i(pass_last),
    .last_beat_o(last_beat), .pass_end_o(pass_end));

  burst_seq_next #(.ADDR_W(ADDR_W)) next_i (
    .cur_i(addr_q), .mask_i(grp_mask), .wrap_active_i(wrap_active),
    .hybrid_i(kind_q == BK_HYBRID), .pass_end_i(pass_end), .next_o(next_addr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q    <= '0;
      code_q    <= '0;
      kind_q    <= BK_WRAP;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      wd_q      <= 1'b0;
      hyb_lin_q <= 1'b0;
    end else if (start_i) begin
      addr_q    <= start_addr_i & ~ADDR_W'(1);
      code_q    <= wrap_code_i;
      kind_q    <= burst_kind_e'(burst_kind_i);
      busy_q    <= 1'b1;
      done_q    <= 1'b0;
      wd_q      <= 1'b0;
      hyb_lin_q <= 1'b0;
    end else if (fire) begin
      if (pass_end && wrap_active) begin
        wd_q <= 1'b1;
        if (kind_q == BK_HYBRID) hyb_lin_q <= 1'b1;
      end
      if (last_beat) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        addr_q <= next_addr;
      end
    end
  end

  assign addr_valid_o = busy_q;
  assign addr_lo_o    = addr_q;
  assign addr_hi_o    = addr_q | ADDR_W'(1);
  assign wrap_done_o  = wd_q;
  assign done_o       = done_q;

  a_r3_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && !addr_ready_i && !start_i) |=> (addr_valid_o && $stable(addr_lo_o)));

  a_r4_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last_beat && is_lin && !start_i) |=> (addr_lo_o == $past(addr_lo_o) + ADDR_W'(2)));

  a_r5_in_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last_beat && kind_q == BK_WRAP && !start_i)
      |=> ((addr_lo_o & ~grp_mask) == ($past(addr_lo_o) & ~grp_mask)));

  a_r7_hybrid_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !last_beat && kind_q == BK_HYBRID && !hyb_lin_q && pass_end && !start_i)
      |=> (addr_lo_o == (($past(addr_lo_o) | grp_mask) + ADDR_W'(1))));

  a_r8_no_wrap_flag_linear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_lin |-> !wrap_done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !addr_valid_o);
endmodule

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int CW = 12;

  typedef struct {
    logic [AW-1:0] lo;
    bit            wd;
    string         tag;
  } beat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ready = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic [1:0] kind = '0, code = '0;
  logic [CW-1:0] cnt = '0;
  logic valid, wdone, done;
  logic [AW-1:0] lo, hi;

  int checks = 0, failures = 0, cyc = 0;
  bit stall_en = 1'b0;
  beat_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  burst_addr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .burst_kind_i(kind), .wrap_code_i(code), .beat_count_i(cnt),
    .addr_valid_o(valid), .addr_ready_i(ready), .addr_lo_o(lo), .addr_hi_o(hi),
    .wrap_done_o(wdone), .done_o(done));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int k,
                                             input int c, input int i);
    int g;
    logic [AW-1:0] s, base;
    int off;
    g    = 16 << c;
    s    = a & ~AW'(1);
    base = s & ~AW'(g - 1);
    off  = int'(s - base);
    if (k == 1 || k == 3) return s + AW'(2 * i);
    if (k == 0 || i < g / 2) return base + AW'((off + 2 * i) % g);
    return base + AW'(g) + AW'(2 * (i - g / 2));
  endfunction

  // Monitor: pops the expected pair whenever a beat is accepted
  logic [AW-1:0] last_stall_lo;
  bit prev_stall = 1'b0, prev_start = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !prev_start) begin
        check(valid && lo == last_stall_lo, "R3 stall hold", lo, last_stall_lo);
      end
      if (valid && ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected beat", lo, 0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(lo == e.lo, e.tag, lo, e.lo);
          check(hi == e.lo + 1, "R2 pair hi", hi, e.lo + 1);
          check(wdone == e.wd, "R8 wrap flag", wdone, e.wd);
        end
      end
      prev_stall    = stall_en && valid && !ready;
      last_stall_lo = lo;
      prev_start    = start;
    end
  end

  task automatic run_burst(input logic [AW-1:0] a, input int k, input int c,
                           input int n, input string tag);
    int beats, g;
    bit lin;
    beats = (n == 0) ? 1 : n;
    g     = 16 << c;
    lin   = (k == 1 || k == 3);
    for (int i = 0; i < beats; i++) begin
      beat_t e;
      e.lo  = exp_addr(a, k, c, i);
      e.wd  = !lin && (i >= g / 2);
      e.tag = tag;
      exp_q.push_back(e);
    end
    @(posedge clk); #1;
    ready = 1'b0; start = 1'b1; saddr = a; kind = 2'(k); code = 2'(c); cnt = CW'(n);
    @(posedge clk); #1;
    start = 1'b0; stall_en = 1'b1;
    check(valid == 1'b1 && lo == (a & ~AW'(1)), "R2 start load", lo, a & ~AW'(1));
    while (!done) begin
      ready = (cyc % 5 != 2) && (cyc % 7 != 4);
      @(posedge clk); #1;
    end
    ready = 1'b0; stall_en = 1'b0;
    @(negedge clk);
    check(done && !valid, "R9 done level", {done, valid}, 2'b10);
    check(wdone == (!lin && beats >= g / 2), "R8 final wrap flag", wdone, !lin && beats >= g / 2);
    check(exp_q.size() == 0, "R9 all beats seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!valid && !done && !wdone, "R1 reset state", {valid, done, wdone}, 0);
    rst_n = 1'b1;
    run_burst(24'h0000FC, 1, 0, 6,  "R4 linear crossing");
    run_burst(24'h001230, 0, 0, 8,  "R5 wrap 16 aligned");
    run_burst(24'h010036, 0, 1, 20, "R6 wrap 32 unaligned");
    run_burst(24'h020102, 0, 2, 40, "R5 wrap 64");
    run_burst(24'h030002, 0, 3, 70, "R6 wrap 128 unaligned");
    run_burst(24'h001235, 2, 0, 14, "R7 hybrid 16 odd start");
    run_burst(24'h0003F0, 2, 2, 40, "R7 hybrid 64");
    run_burst(24'h00FFFA, 3, 1, 5,  "R4 kind3 linear");
    run_burst(24'h000444, 0, 0, 0,  "R9 zero count");
    // R10: restart while a burst is pending
    @(posedge clk); #1;
    ready = 1'b0; start = 1'b1; saddr = 24'h000500; kind = 2'd1; code = 2'd0; cnt = CW'(3);
    @(posedge clk); #1;
    start = 1'b0;
    check(valid && lo == 24'h000500, "R10 first burst active", lo, 24'h000500);
    run_burst(24'h004448, 2, 0, 12, "R10 restart sequence");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule